// File: doc/BRIEF.md
# Dual-Convention Parallel Host Bus Front End

This block sits between an external microprocessor and the rest of a small graphic display controller. It takes an 8-bit parallel bus whose pins can follow either of two conventions: separate active-low read and write strobes, or a single read/write direction line plus an active-high enable. A static mode pin chooses the convention. Two chip-select inputs, one active-low and one active-high, must both be asserted before any strobe has an effect.

The bus pins are asynchronous to the controller clock. All of them, including the data byte and the A0 byte-type flag, pass together through a synchronizer chain, and edge detection turns each completed write into a single-cycle event. The event carries the byte and a flag that tells display data from a command byte. Each read strobe produces a single-cycle read request at its start. A neighbouring block answers with a response beat, and the byte it returns is held on the outgoing data lines. The output-enable for the external tri-state driver is decoded straight from the pins, so it drops as soon as the read strobe or the chip select goes away.

The write-event and read-request streams carry a valid only. The external host cannot be stalled, so there is no back-pressure: a consumer must take every beat in the cycle it appears. The read response is also valid-only, and each beat simply overwrites the held byte.

Top module: `mpu_bus_front`

## Requirements
- R1: The block counts as selected only while `cs1_n` is 0 and `cs2` is 1. With any other chip-select combination, `dout_oe` stays 0 and no strobe activity produces a write event or a read request.
- R2: `mode_6800` = 1 selects the enable-strobe convention (`rdwr` is direction, 1 = read and 0 = write; `enrd` is an active-high enable). `mode_6800` = 0 selects the dual-strobe convention (`rdwr` is an active-low write strobe; `enrd` is an active-low read strobe).
- R3: In dual-strobe mode, a selected low pulse on `rdwr` produces exactly one write event after `rdwr` returns high. The event carries the `din` value that was present while the strobe was low.
- R4: In dual-strobe mode, `dout_oe` is 1 exactly while the block is selected and `enrd` is 0.
- R5: In enable-strobe mode, a selected pulse of `enrd` with `rdwr` = 0 produces exactly one write event after `enrd` falls. The event carries the `din` value present during the pulse.
- R6: In enable-strobe mode, `dout_oe` is 1 exactly while the block is selected, `enrd` is 1 and `rdwr` is 1.
- R7: `wr_is_data` equals the A0 level present during the write strobe: 1 marks a display-data byte and 0 marks a command byte.
- R8: `wr_valid` is high for a single clock cycle per completed write. It rises within 5 clock cycles after the strobe ends, and it is never asserted in two consecutive cycles.
- R9: Each selected read strobe raises `rd_req` for exactly one cycle, within 5 clock cycles after the strobe begins and while the strobe is still active.
- R10: When `rd_resp_valid` is 1 at a clock edge, `dout` takes `rd_resp_data` at that edge. Otherwise `dout` holds its value.
- R11: While `rst_n` is 0, `wr_valid`, `rd_req`, `wr_data`, `wr_is_data` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_6800 | input | 1 | Static bus convention select (1 = enable strobe, 0 = dual strobe) |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| a0 | input | 1 | Byte type: 1 = display data, 0 = command |
| rdwr | input | 1 | Write strobe (dual-strobe) or direction (enable-strobe) |
| enrd | input | 1 | Read strobe (dual-strobe) or enable (enable-strobe) |
| din | input | DATA_W | Data bus input side |
| dout | output | DATA_W | Data bus output side, held read byte |
| dout_oe | output | 1 | Tri-state output-enable for the data bus |
| wr_valid | output | 1 | Single-cycle write event |
| wr_data | output | DATA_W | Byte carried by the write event |
| wr_is_data | output | 1 | Byte-type flag carried by the write event |
| rd_req | output | 1 | Single-cycle read request |
| rd_resp_valid | input | 1 | Read response beat from the neighbour |
| rd_resp_data | input | DATA_W | Read response byte |

## Verification
The assertions take for granted that the mode pin only changes while the block is deselected, and that each strobe stays active and inactive for longer than the synchronizer depth. They also assume that `din` and `a0` are stable from before the strobe begins until a couple of cycles after it ends. The stimulus tasks meet these conditions. They switch mode only with both chip selects off, hold every strobe for several clocks, keep data steady through the strobe, and change data only two cycles after the strobe ends, so any byte sampled too late would be caught. Random transactions in both conventions are mixed with directed ones for each non-selecting chip-select combination and for the extreme byte values.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;

  localparam int BYTE_W = 8;

  // Synchronised control pins. rw/en carry the two strobe pins whose
  // meaning depends on the bus convention.
  typedef struct packed {
    logic sel;   // both chip selects asserted
    logic rw;    // write strobe (dual-strobe) or direction (enable-strobe)
    logic en;    // read strobe (dual-strobe) or enable (enable-strobe)
    logic a0;    // byte type
  } bus_ctrl_t;

  typedef struct packed {
    logic wr;
    logic rd;
  } strobe_t;

  function automatic strobe_t decode_strobe(input logic mode_6800, input bus_ctrl_t c);
    strobe_t s;
    if (mode_6800) begin
      s.wr = c.sel & c.en & ~c.rw;
      s.rd = c.sel & c.en & c.rw;
    end else begin
      s.wr = c.sel & ~c.rw;
      s.rd = c.sel & ~c.en;
    end
    return s;
  endfunction

endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_st[i-1].r;
      end
    end
  end

  assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/mpu_strobe_decode.sv
module mpu_strobe_decode
  import mpu_bus_pkg::*;
(
  input  logic      mode_6800,
  input  bus_ctrl_t ctrl,
  output logic      wr_act,
  output logic      rd_act
);

  strobe_t s;

  always_comb begin
    s      = decode_strobe(mode_6800, ctrl);
    wr_act = s.wr;
    rd_act = s.rd;
  end

endmodule

// File: rtl/mpu_bus_front.sv
module mpu_bus_front
  import mpu_bus_pkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_6800,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              a0,
  input  logic              rdwr,
  input  logic              enrd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_is_data,
  output logic              rd_req,
  input  logic              rd_resp_valid,
  input  logic [DATA_W-1:0] rd_resp_data
);

  localparam int CTRL_W = $bits(bus_ctrl_t);
  localparam int SYNC_W = CTRL_W + DATA_W;

  bus_ctrl_t           raw_ctrl, now_ctrl, prev_ctrl;
  logic [DATA_W-1:0]   now_data, prev_data;
  logic [SYNC_W-1:0]   sync_q;
  logic                wr_now, rd_now, wr_prev, rd_prev;
  strobe_t             raw_strobe;

  assign raw_ctrl = '{sel: ~cs1_n & cs2, rw: rdwr, en: enrd, a0: a0};

  // Pins, flag and data share one chain so that they stay aligned.
  mpu_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({raw_ctrl, din}),
    .q     (sync_q)
  );

  assign now_ctrl = bus_ctrl_t'(sync_q[SYNC_W-1:DATA_W]);
  assign now_data = sync_q[DATA_W-1:0];

  // One more stage for edge detection; prev_data is the byte seen while
  // the strobe was still active when its trailing edge is detected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ctrl <= '0;
      prev_data <= '0;
    end else begin
      prev_ctrl <= now_ctrl;
      prev_data <= now_data;
    end
  end

  mpu_strobe_decode u_dec_now (
    .mode_6800 (mode_6800),
    .ctrl      (now_ctrl),
    .wr_act    (wr_now),
    .rd_act    (rd_now)
  );

  mpu_strobe_decode u_dec_prev (
    .mode_6800 (mode_6800),
    .ctrl      (prev_ctrl),
    .wr_act    (wr_prev),
    .rd_act    (rd_prev)
  );

  // Write completes on the trailing edge, read request on the leading edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      wr_is_data <= 1'b0;
      rd_req     <= 1'b0;
    end else begin
      wr_valid <= wr_prev & ~wr_now;
      rd_req   <= rd_now & ~rd_prev;
      if (wr_prev & ~wr_now) begin
        wr_data    <= prev_data;
        wr_is_data <= prev_ctrl.a0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dout <= '0;
    else if (rd_resp_valid) dout <= rd_resp_data;
  end

  // Bus drive follows the raw pins so it releases without clock latency.
  assign raw_strobe = decode_strobe(mode_6800, raw_ctrl);
  assign dout_oe    = raw_strobe.rd;

endmodule

// File: rtl/mpu_bus_front_chk.sv
module mpu_bus_front_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_6800,
  input logic              cs1_n,
  input logic              cs2,
  input logic              rdwr,
  input logic              enrd,
  input logic              dout_oe,
  input logic              wr_valid,
  input logic              rd_req,
  input logic              rd_resp_valid,
  input logic [DATA_W-1:0] dout
);

  assert_oe_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!cs1_n && cs2));

  assert_oe_dual_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_6800 && dout_oe) |-> !enrd);

  assert_oe_enable_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_6800 && dout_oe) |-> (enrd && rdwr));

  assert_wr_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_rd_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_no_wr_rd_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_req));

  assert_dout_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_resp_valid) |-> $stable(dout));

endmodule

bind mpu_bus_front mpu_bus_front_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mpu_bus_front.sv
module sim_mpu_bus_front;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_6800 = 1'b0;
  logic       cs1_n = 1'b1;
  logic       cs2 = 1'b0;
  logic       a0 = 1'b0;
  logic       rdwr = 1'b1;
  logic       enrd = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_oe;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       wr_is_data;
  logic       rd_req;
  logic       rd_resp_valid = 1'b0;
  logic [7:0] rd_resp_data = 8'h00;

  int n_cmp = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] last_wr_data = 8'h00;
  logic       last_wr_flag = 1'b0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  mpu_bus_front u0 (
    .clk, .rst_n, .mode_6800, .cs1_n, .cs2, .a0, .rdwr, .enrd, .din,
    .dout, .dout_oe, .wr_valid, .wr_data, .wr_is_data, .rd_req,
    .rd_resp_valid, .rd_resp_data
  );

  // Event monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      wr_cnt++;
      last_wr_data = wr_data;
      last_wr_flag = wr_is_data;
    end
    if (rst_n && rd_req) rd_cnt++;
  end

  function automatic bit exp_selected(input logic c1n, input logic c2);
    return (!c1n && c2);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cs1_n = 1'b1; cs2 = 1'b0;
    mode_6800 = m;
    rdwr = 1'b1;
    enrd = m ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic c1n, input logic c2, input logic a0v, input logic [7:0] b);
    int  c0 = wr_cnt;
    bit  s  = exp_selected(c1n, c2);
    @(negedge clk);
    cs1_n = c1n; cs2 = c2; a0 = a0v; din = b;
    if (mode_6800) rdwr = 1'b0;
    @(negedge clk);
    if (mode_6800) enrd = 1'b1; else rdwr = 1'b0;
    repeat (3) @(negedge clk);
    if (mode_6800) enrd = 1'b0; else rdwr = 1'b1;
    repeat (2) @(negedge clk);
    din = ~b; a0 = ~a0v;                 // late change must not be captured
    repeat (6) @(negedge clk);
    rdwr = 1'b1; cs1_n = 1'b1; cs2 = 1'b0;
    // R3 (dual strobe) / R5 (enable strobe) / R1 (selection): event count
    chk((wr_cnt - c0) == (s ? 1 : 0), mode_6800 ? "R5 write event count" : "R3 write event count",
        wr_cnt - c0, s ? 1 : 0);
    if (s) begin
      chk(last_wr_data == b, mode_6800 ? "R5 write byte" : "R3 write byte", last_wr_data, b);
      chk(last_wr_flag == a0v, "R7 byte-type flag", last_wr_flag, a0v);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic c1n, input logic c2, input logic [7:0] resp);
    int  c0   = rd_cnt;
    bit  s    = exp_selected(c1n, c2);
    bit  seen = 1'b0;
    @(negedge clk);
    cs1_n = c1n; cs2 = c2; rdwr = 1'b1;
    @(negedge clk);
    if (mode_6800) enrd = 1'b1; else enrd = 1'b0;
    #1;
    chk(dout_oe == s, mode_6800 ? "R6 oe on strobe" : "R4 oe on strobe", dout_oe, s);
    for (int i = 0; i < 6 && !seen; i++) begin
      @(negedge clk);
      if (rd_req) seen = 1'b1;
    end
    chk(seen == s, "R9 read request at strobe start", seen, s);
    if (seen) begin
      rd_resp_valid = 1'b1; rd_resp_data = resp;
      @(negedge clk);
      rd_resp_valid = 1'b0; rd_resp_data = ~resp;
      @(negedge clk);
      chk(dout == resp, "R10 returned byte held", dout, resp);
      chk(dout_oe == 1'b1, mode_6800 ? "R6 oe during strobe" : "R4 oe during strobe", dout_oe, 1);
    end
    if (mode_6800) enrd = 1'b0; else enrd = 1'b1;
    #1;
    chk(dout_oe == 1'b0, mode_6800 ? "R6 oe release" : "R4 oe release", dout_oe, 0);
    repeat (6) @(negedge clk);
    chk((rd_cnt - c0) == (s ? 1 : 0), "R9 one request per strobe", rd_cnt - c0, s ? 1 : 0);
    cs1_n = 1'b1; cs2 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(wr_valid == 0, "R11 wr_valid in reset", wr_valid, 0);
    chk(rd_req == 0, "R11 rd_req in reset", rd_req, 0);
    chk(wr_data == 0 && wr_is_data == 0, "R11 write fields in reset", wr_data, 0);
    chk(dout == 0, "R11 dout in reset", dout, 0);
    chk(dout_oe == 0, "R1 oe deselected", dout_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed: dual strobe (R2 mode 0)
    set_mode(1'b0);
    do_write(1'b0, 1'b1, 1'b1, 8'hA5);
    do_write(1'b0, 1'b1, 1'b0, 8'h00);
    do_write(1'b0, 1'b1, 1'b1, 8'hFF);
    do_write(1'b1, 1'b1, 1'b1, 8'h3C);   // R1: cs1_n high
    do_write(1'b0, 1'b0, 1'b0, 8'hC3);   // R1: cs2 low
    do_read(1'b0, 1'b1, 8'h5A);
    do_read(1'b1, 1'b0, 8'h77);          // R1: deselected read
    // Directed: enable strobe (R2 mode 1)
    set_mode(1'b1);
    do_write(1'b0, 1'b1, 1'b0, 8'h81);
    do_write(1'b0, 1'b1, 1'b1, 8'h7E);
    do_write(1'b1, 1'b1, 1'b1, 8'h11);   // R1
    do_read(1'b0, 1'b1, 8'hE7);
    do_read(1'b0, 1'b0, 8'h18);          // R1

    // Constrained random mix
    for (int k = 0; k < 60; k++) begin
      logic m  = logic'($urandom_range(0, 1));
      int   sv = $urandom_range(0, 9);
      logic c1n = (sv == 8) ? 1'b1 : 1'b0;
      logic c2  = (sv == 9) ? 1'b0 : 1'b1;
      if (m != mode_6800) set_mode(m);
      if ($urandom_range(0, 2) != 0)
        do_write(c1n, c2, logic'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
      else
        do_read(c1n, c2, 8'($urandom_range(0, 255)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule